// File: doc/BRIEF.md
# Hardware Trap Priority Arbiter

This block gathers the exception conditions that can arise while one instruction executes and decides which one the processor services next. Every hardware condition sets a sticky bit in a flag register that software reads and clears, and also sets an internal pending bit. A three-level scheme picks one winner from the pending bits. Reset requests rank highest, then the per-vector class A traps, then the class B faults that share one vector. Software trap requests rank lowest and may carry any 7-bit trap number.

The winner is announced by a one-cycle strobe together with its trap number, its vector address (always the trap number times four), its class level and the priority at which its service routine runs. Hardware traps and resets run at the top priority, 15. A software trap runs at the CPU priority level that was present when it was requested. After a strobe the block waits for an acknowledge before it arbitrates again. The only exception is a reset request, which is taken even while the block waits.

Top module: `trap_arbiter`

## Requirements
- R1: After `rst_n` is released, `trap_take_o` is 0, `flags_o` is 0 and `rst_cause_o` is 0 (pin reset).
- R2: A high `cond_a_i`/`cond_b_i` bit sampled at a clock edge sets its flag bit at that edge. The flag bits are ordered as follows: bit 0 for the non-maskable interrupt, bit 1 for stack overflow, bit 2 for stack underflow, and bits 3 to 7 for undefined opcode, protected instruction, misaligned word operand, bad instruction fetch and external bus fault. A set flag stays set.
- R3: A flag write (`flag_wr_i`) clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. A condition raised in the same cycle wins over the clear. A write never sets a flag and never causes a trap.
- R4: With the block idle, a condition sampled at edge k gives a one-cycle `trap_take_o` pulse after edge k+1. `trap_vec_o` equals `trap_num_o` times 4.
- R5: Class A traps use trap number 2 (non-maskable interrupt), 4 (stack overflow) and 6 (stack underflow). They report level code 2 and priority 15. When several are raised together they are served in that order, one per strobe, and the losers stay pending.
- R6: Any class B fault gives trap number 0x0A (vector 0x28), level code 1 and priority 15. All class B faults pending together are served by a single strobe.
- R7: The class order is reset, then class A, then class B, then software.
- R8: A software trap (`sw_trap_i`) gives the requested number (0x00 to 0x7F), vector number×4, level code 0, and priority equal to `cpu_lvl_i` sampled with the request. A further request made while one is still pending is ignored.
- R9: After a strobe, no new non-reset strobe occurs until `take_ack_i` is sampled high. If the acknowledge is sampled at edge k, the next pending trap is strobed at edge k+1.
- R10: A software reset (`sw_rst_i`) or watchdog reset (`wdt_rst_i`) request gives trap number 0, vector 0, level code 3 and priority 15, even while an acknowledge is outstanding. The strobe clears every flag and every pending trap. `rst_cause_o` becomes 1 for a software reset and 2 for a watchdog reset, with the watchdog taking precedence when both are requested together.
- R11: Trap numbers 0x0B to 0x0F are never produced by a hardware condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous pin reset, active low |
| cond_a_i | input | 3 | Class A conditions raised this cycle |
| cond_b_i | input | 5 | Class B faults raised this cycle |
| sw_trap_i | input | 1 | Software trap request |
| sw_num_i | input | 7 | Requested software trap number |
| cpu_lvl_i | input | 4 | Current CPU priority level |
| sw_rst_i | input | 1 | Software reset request |
| wdt_rst_i | input | 1 | Watchdog reset request |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Flag write data, a 0 bit clears its flag |
| take_ack_i | input | 1 | Acknowledge of the last strobe |
| trap_take_o | output | 1 | One-cycle strobe qualifying the outputs below |
| trap_vec_o | output | 9 | Vector address |
| trap_num_o | output | 7 | Trap number |
| trap_lvl_o | output | 2 | Class level: 3 reset, 2 class A, 1 class B, 0 software |
| trap_prio_o | output | 4 | Priority of the service routine |
| flags_o | output | 8 | Sticky trap flags |
| rst_cause_o | output | 2 | Last reset source: 0 pin, 1 software, 2 watchdog |

## Verification
The assertions assume that the inputs change only between clock edges and that a condition bit is a level sampled once per cycle. The strobe-spacing property assumes the acknowledge is the only thing that ends the wait, except for a reset request. The bench drives every input at the falling edge and pulses conditions for exactly one cycle. It withholds the acknowledge on purpose when it probes the wait and the reset pre-emption, and otherwise acknowledges until all pending traps have drained. It clears the flags between table rows so that each row starts idle with an empty register.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int TNUM_W = 7;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = TNUM_W + 2;

  typedef enum logic [1:0] {
    LVL_SW  = 2'd0,
    LVL_B   = 2'd1,
    LVL_A   = 2'd2,
    LVL_RST = 2'd3
  } trap_lvl_e;

  typedef enum logic [1:0] {
    CAUSE_PIN  = 2'd0,
    CAUSE_SOFT = 2'd1,
    CAUSE_WDOG = 2'd2
  } rst_cause_e;

  // vector address = trap number scaled by four
  function automatic logic [VEC_W-1:0] vec_of(input logic [TNUM_W-1:0] n);
    return {n, 2'b00};
  endfunction

  // class A trap numbers step by two starting at two
  function automatic logic [TNUM_W-1:0] a_num(input int unsigned idx);
    return TNUM_W'(2 * (idx + 1));
  endfunction

  function automatic logic is_reserved(input logic [TNUM_W-1:0] n);
    return (n >= TNUM_W'(11)) && (n <= TNUM_W'(15));
  endfunction
endpackage

// File: rtl/trap_flag_bank.sv
module trap_flag_bank #(
  parameter int NUM_A = 3,
  parameter int NUM_B = 5,
  localparam int FW = NUM_A + NUM_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_A-1:0] cond_a,
  input  logic [NUM_B-1:0] cond_b,
  input  logic             wr_en,
  input  logic [FW-1:0]    wr_data,
  input  logic [NUM_A-1:0] clr_a,
  input  logic             clr_b,
  input  logic             clr_all,
  output logic [FW-1:0]    flags,
  output logic [NUM_A-1:0] pend_a,
  output logic [NUM_B-1:0] pend_b
);
  logic [FW-1:0] raise_all;
  logic [FW-1:0] soft_clr;

  assign raise_all = {cond_b, cond_a};
  assign soft_clr  = {FW{wr_en}} & ~wr_data;

  generate
    for (genvar i = 0; i < FW; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            q <= 1'b0;
        else if (clr_all)      q <= 1'b0;
        else if (raise_all[i]) q <= 1'b1;
        else if (soft_clr[i])  q <= 1'b0;
      end
      assign flags[i] = q;

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !soft_clr[i] && !clr_all) |=> flags[i]); // R2
      AST_FLAG_ONLY_BY_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[i] && !raise_all[i]) |=> !flags[i]); // R3
    end

    for (genvar i = 0; i < NUM_A; i++) begin : g_pend_a
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= 1'b0;
        else if (clr_all)   q <= 1'b0;
        else if (cond_a[i]) q <= 1'b1;
        else if (clr_a[i])  q <= 1'b0;
      end
      assign pend_a[i] = q;
    end

    for (genvar j = 0; j < NUM_B; j++) begin : g_pend_b
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= 1'b0;
        else if (clr_all)   q <= 1'b0;
        else if (cond_b[j]) q <= 1'b1;
        else if (clr_b)     q <= 1'b0;
      end
      assign pend_b[j] = q;
    end
  endgenerate

  AST_LOSER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a[1] && !clr_a[1] && !clr_all) |=> pend_a[1]); // R5
endmodule

// File: rtl/trap_req_latch.sv
module trap_req_latch import trap_arb_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [TNUM_W-1:0] sw_num_in,
  input  logic [PRIO_W-1:0] lvl_in,
  input  logic              sw_rst,
  input  logic              wdt_rst,
  input  logic              clr_sw,
  input  logic              clr_all,
  output logic              sw_pend,
  output logic [TNUM_W-1:0] sw_num,
  output logic [PRIO_W-1:0] sw_lvl,
  output logic              rst_pend,
  output logic [1:0]        cause
);
  logic sw_accept;
  assign sw_accept = sw_req && (!sw_pend || clr_sw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend  <= 1'b0;
      sw_num   <= '0;
      sw_lvl   <= '0;
      rst_pend <= 1'b0;
      cause    <= CAUSE_PIN;
    end else begin
      if (clr_all) begin
        sw_pend <= 1'b0;
      end else if (sw_accept) begin
        sw_pend <= 1'b1;
        sw_num  <= sw_num_in;
        sw_lvl  <= lvl_in;
      end else if (clr_sw) begin
        sw_pend <= 1'b0;
      end

      if (sw_rst || wdt_rst) begin
        rst_pend <= 1'b1;
        cause    <= wdt_rst ? CAUSE_WDOG : CAUSE_SOFT;
      end else if (clr_all) begin
        rst_pend <= 1'b0;
      end
    end
  end

  AST_SW_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pend && !clr_sw && !clr_all) |=> (sw_pend && $stable(sw_num) && $stable(sw_lvl))); // R8
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (cause == CAUSE_WDOG)); // R10
endmodule

// File: rtl/trap_select.sv
module trap_select import trap_arb_pkg::*; #(
  parameter int NUM_A = 3,
  parameter int NUM_B = 5,
  parameter logic [TNUM_W-1:0] B_NUM = 7'h0A,
  parameter int TOP_PRIO = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pend,
  input  logic [NUM_A-1:0]  pend_a,
  input  logic [NUM_B-1:0]  pend_b,
  input  logic              sw_pend,
  input  logic [TNUM_W-1:0] sw_num,
  input  logic [PRIO_W-1:0] sw_lvl,
  output logic              sel_valid,
  output logic [1:0]        sel_lvl,
  output logic [TNUM_W-1:0] sel_num,
  output logic [PRIO_W-1:0] sel_prio,
  output logic [NUM_A-1:0]  a_onehot,
  output logic              win_rst,
  output logic              win_a,
  output logic              win_b,
  output logic              win_sw
);
  logic [TNUM_W-1:0] a_pick;
  logic any_a, any_b;

  assign any_a = |pend_a;
  assign any_b = |pend_b;

  // lowest index wins inside class A
  always_comb begin
    a_onehot = '0;
    a_pick   = '0;
    for (int i = NUM_A - 1; i >= 0; i--) begin
      if (pend_a[i]) begin
        a_onehot    = '0;
        a_onehot[i] = 1'b1;
        a_pick      = a_num(unsigned'(i));
      end
    end
  end

  assign win_rst   = rst_pend;
  assign win_a     = !rst_pend && any_a;
  assign win_b     = !rst_pend && !any_a && any_b;
  assign win_sw    = !rst_pend && !any_a && !any_b && sw_pend;
  assign sel_valid = win_rst || win_a || win_b || win_sw;

  always_comb begin
    if (win_rst) begin
      sel_num  = '0;
      sel_lvl  = LVL_RST;
      sel_prio = PRIO_W'(TOP_PRIO);
    end else if (win_a) begin
      sel_num  = a_pick;
      sel_lvl  = LVL_A;
      sel_prio = PRIO_W'(TOP_PRIO);
    end else if (win_b) begin
      sel_num  = B_NUM;
      sel_lvl  = LVL_B;
      sel_prio = PRIO_W'(TOP_PRIO);
    end else begin
      sel_num  = sw_num;
      sel_lvl  = LVL_SW;
      sel_prio = sw_lvl;
    end
  end

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_rst, win_a, win_b, win_sw})); // R7
  AST_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a != '0) |-> $onehot0(a_onehot) && (a_onehot != '0)); // R5
endmodule

// File: rtl/trap_issue.sv
module trap_issue import trap_arb_pkg::*; #(
  parameter int NUM_A = 3,
  parameter int TOP_PRIO = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [1:0]        sel_lvl,
  input  logic [TNUM_W-1:0] sel_num,
  input  logic [PRIO_W-1:0] sel_prio,
  input  logic [NUM_A-1:0]  a_onehot,
  input  logic              win_rst,
  input  logic              win_a,
  input  logic              win_b,
  input  logic              win_sw,
  input  logic              take_ack,
  output logic              take,
  output logic [VEC_W-1:0]  vec,
  output logic [TNUM_W-1:0] num,
  output logic [1:0]        lvl,
  output logic [PRIO_W-1:0] prio,
  output logic [NUM_A-1:0]  clr_a,
  output logic              clr_b,
  output logic              clr_sw,
  output logic              clr_all
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st;
  logic go;

  assign go      = win_rst || (st == ST_IDLE && sel_valid);
  assign clr_all = go && win_rst;
  assign clr_a   = (go && win_a) ? a_onehot : '0;
  assign clr_b   = go && win_b;
  assign clr_sw  = go && win_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      take <= 1'b0;
      vec  <= '0;
      num  <= '0;
      lvl  <= '0;
      prio <= '0;
    end else begin
      take <= go;
      if (go) begin
        st   <= ST_WAIT;
        num  <= sel_num;
        vec  <= vec_of(sel_num);
        lvl  <= sel_lvl;
        prio <= sel_prio;
      end else if (st == ST_WAIT && take_ack) begin
        st <= ST_IDLE;
      end
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!take || lvl == LVL_RST)); // R4
  AST_WAIT_FOR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !take_ack && !win_rst) |=> !take); // R9
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && lvl != LVL_SW) |-> !is_reserved(num)); // R11
  AST_HW_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && lvl != LVL_SW) |-> (prio == PRIO_W'(TOP_PRIO))); // R5
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter import trap_arb_pkg::*; #(
  parameter int NUM_A = 3,
  parameter int NUM_B = 5,
  parameter logic [TNUM_W-1:0] B_NUM = 7'h0A,
  parameter int TOP_PRIO = 15,
  localparam int FLAG_W = NUM_A + NUM_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_A-1:0]  cond_a_i,
  input  logic [NUM_B-1:0]  cond_b_i,
  input  logic              sw_trap_i,
  input  logic [TNUM_W-1:0] sw_num_i,
  input  logic [PRIO_W-1:0] cpu_lvl_i,
  input  logic              sw_rst_i,
  input  logic              wdt_rst_i,
  input  logic              flag_wr_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  input  logic              take_ack_i,
  output logic              trap_take_o,
  output logic [VEC_W-1:0]  trap_vec_o,
  output logic [TNUM_W-1:0] trap_num_o,
  output logic [1:0]        trap_lvl_o,
  output logic [PRIO_W-1:0] trap_prio_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [1:0]        rst_cause_o
);
  logic [NUM_A-1:0]  pend_a, a_onehot, clr_a;
  logic [NUM_B-1:0]  pend_b;
  logic              clr_b, clr_sw, clr_all;
  logic              sw_pend, rst_pend;
  logic [TNUM_W-1:0] sw_num, sel_num;
  logic [PRIO_W-1:0] sw_lvl, sel_prio;
  logic [1:0]        sel_lvl;
  logic              sel_valid, win_rst, win_a, win_b, win_sw;

  trap_flag_bank #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_flags (
    .clk(clk), .rst_n(rst_n), .cond_a(cond_a_i), .cond_b(cond_b_i),
    .wr_en(flag_wr_i), .wr_data(flag_wdata_i), .clr_a(clr_a), .clr_b(clr_b),
    .clr_all(clr_all), .flags(flags_o), .pend_a(pend_a), .pend_b(pend_b)
  );

  trap_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_trap_i), .sw_num_in(sw_num_i),
    .lvl_in(cpu_lvl_i), .sw_rst(sw_rst_i), .wdt_rst(wdt_rst_i),
    .clr_sw(clr_sw), .clr_all(clr_all), .sw_pend(sw_pend), .sw_num(sw_num),
    .sw_lvl(sw_lvl), .rst_pend(rst_pend), .cause(rst_cause_o)
  );

  trap_select #(.NUM_A(NUM_A), .NUM_B(NUM_B), .B_NUM(B_NUM), .TOP_PRIO(TOP_PRIO)) u_sel (
    .clk(clk), .rst_n(rst_n), .rst_pend(rst_pend), .pend_a(pend_a), .pend_b(pend_b),
    .sw_pend(sw_pend), .sw_num(sw_num), .sw_lvl(sw_lvl), .sel_valid(sel_valid),
    .sel_lvl(sel_lvl), .sel_num(sel_num), .sel_prio(sel_prio), .a_onehot(a_onehot),
    .win_rst(win_rst), .win_a(win_a), .win_b(win_b), .win_sw(win_sw)
  );

  trap_issue #(.NUM_A(NUM_A), .TOP_PRIO(TOP_PRIO)) u_issue (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_lvl(sel_lvl),
    .sel_num(sel_num), .sel_prio(sel_prio), .a_onehot(a_onehot),
    .win_rst(win_rst), .win_a(win_a), .win_b(win_b), .win_sw(win_sw),
    .take_ack(take_ack_i), .take(trap_take_o), .vec(trap_vec_o),
    .num(trap_num_o), .lvl(trap_lvl_o), .prio(trap_prio_o),
    .clr_a(clr_a), .clr_b(clr_b), .clr_sw(clr_sw), .clr_all(clr_all)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take_o && trap_lvl_o == LVL_RST) |-> (flags_o == '0)); // R10
endmodule

// File: tb/trap_arbiter_test.sv
`timescale 1ns/1ps
module trap_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cond_a_i = '0;
  logic [4:0] cond_b_i = '0;
  logic       sw_trap_i = 1'b0;
  logic [6:0] sw_num_i = '0;
  logic [3:0] cpu_lvl_i = '0;
  logic       sw_rst_i = 1'b0;
  logic       wdt_rst_i = 1'b0;
  logic       flag_wr_i = 1'b0;
  logic [7:0] flag_wdata_i = '0;
  logic       take_ack_i = 1'b0;
  logic       trap_take_o;
  logic [8:0] trap_vec_o;
  logic [6:0] trap_num_o;
  logic [1:0] trap_lvl_o;
  logic [3:0] trap_prio_o;
  logic [7:0] flags_o;
  logic [1:0] rst_cause_o;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  trap_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cond_a_i(cond_a_i), .cond_b_i(cond_b_i),
    .sw_trap_i(sw_trap_i), .sw_num_i(sw_num_i), .cpu_lvl_i(cpu_lvl_i),
    .sw_rst_i(sw_rst_i), .wdt_rst_i(wdt_rst_i), .flag_wr_i(flag_wr_i),
    .flag_wdata_i(flag_wdata_i), .take_ack_i(take_ack_i),
    .trap_take_o(trap_take_o), .trap_vec_o(trap_vec_o), .trap_num_o(trap_num_o),
    .trap_lvl_o(trap_lvl_o), .trap_prio_o(trap_prio_o), .flags_o(flags_o),
    .rst_cause_o(rst_cause_o)
  );

  typedef struct packed {
    logic [2:0] a;
    logic [4:0] b;
    logic       sw;
    logic [6:0] swn;
    logic [3:0] lvl;
    logic [6:0] enum_n;
    logic [1:0] ecls;
    logic [3:0] eprio;
  } row_t;

  // a, b, sw, sw number, cpu level -> expected number, level code, priority
  localparam row_t TBL [10] = '{
    '{3'b001, 5'b00000, 1'b0, 7'h00, 4'h0, 7'h02, 2'd2, 4'd15},
    '{3'b010, 5'b00000, 1'b0, 7'h00, 4'h0, 7'h04, 2'd2, 4'd15},
    '{3'b100, 5'b00000, 1'b0, 7'h00, 4'h0, 7'h06, 2'd2, 4'd15},
    '{3'b110, 5'b00000, 1'b0, 7'h00, 4'h0, 7'h04, 2'd2, 4'd15},
    '{3'b000, 5'b00001, 1'b0, 7'h00, 4'h0, 7'h0A, 2'd1, 4'd15},
    '{3'b000, 5'b10000, 1'b0, 7'h00, 4'h0, 7'h0A, 2'd1, 4'd15},
    '{3'b100, 5'b11111, 1'b0, 7'h00, 4'h0, 7'h06, 2'd2, 4'd15},
    '{3'b000, 5'b00000, 1'b1, 7'h7F, 4'h5, 7'h7F, 2'd0, 4'd5},
    '{3'b000, 5'b00000, 1'b1, 7'h0C, 4'h0, 7'h0C, 2'd0, 4'd0},
    '{3'b000, 5'b00100, 1'b1, 7'h03, 4'h9, 7'h0A, 2'd1, 4'd15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    take_ack_i = 1'b1;
    repeat (10) tick();
    take_ack_i = 1'b0;
    flag_wr_i = 1'b1;
    flag_wdata_i = 8'h00;
    tick();
    flag_wr_i = 1'b0;
    tick();
  endtask

  task automatic ack_expect(input logic exp_take, input logic [6:0] exp_num, input string req);
    take_ack_i = 1'b1;
    tick();
    take_ack_i = 1'b0;
    chk({req, " no strobe on ack edge"}, 32'(trap_take_o), 32'd0);
    tick();
    chk({req, " strobe after ack"}, 32'(trap_take_o), 32'(exp_take));
    if (exp_take) chk({req, " number"}, 32'(trap_num_o), 32'(exp_num));
  endtask

  task automatic raise(input logic [2:0] a, input logic [4:0] b);
    cond_a_i = a;
    cond_b_i = b;
    tick();
    cond_a_i = '0;
    cond_b_i = '0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 strobe idle", 32'(trap_take_o), 32'd0);
    chk("R1 flags clear", 32'(flags_o), 32'd0);
    chk("R1 cause pin", 32'(rst_cause_o), 32'd0);

    for (int k = 0; k < 10; k++) begin
      cond_a_i = TBL[k].a;
      cond_b_i = TBL[k].b;
      sw_trap_i = TBL[k].sw;
      sw_num_i = TBL[k].swn;
      cpu_lvl_i = TBL[k].lvl;
      tick();
      cond_a_i = '0;
      cond_b_i = '0;
      sw_trap_i = 1'b0;
      cpu_lvl_i = 4'hF;
      tick();
      chk("R4 strobe", 32'(trap_take_o), 32'd1);
      chk("R7 R5 R6 R8 number", 32'(trap_num_o), 32'(TBL[k].enum_n));
      chk("R4 vector", 32'(trap_vec_o), 32'(TBL[k].enum_n) * 4);
      chk("R7 level", 32'(trap_lvl_o), 32'(TBL[k].ecls));
      chk("R8 R5 priority", 32'(trap_prio_o), 32'(TBL[k].eprio));
      if (TBL[k].ecls != 2'd0)
        chk("R11 not reserved", 32'(trap_num_o >= 7'h0B && trap_num_o <= 7'h0F), 32'd0);
      tick();
      chk("R4 single cycle", 32'(trap_take_o), 32'd0);
      drain();
    end

    // R2 R3: sticky flags and write-zero-to-clear
    cond_b_i = 5'b10000;
    tick();
    cond_b_i = '0;
    chk("R2 bus fault flag bit 7", 32'(flags_o), 32'h80);
    tick();
    flag_wr_i = 1'b1;
    flag_wdata_i = 8'hFF;
    tick();
    chk("R3 write ones keeps", 32'(flags_o), 32'h80);
    flag_wdata_i = 8'h7F;
    tick();
    flag_wr_i = 1'b0;
    chk("R3 write zero clears", 32'(flags_o), 32'h00);
    ack_expect(1'b0, 7'h00, "R3");
    flag_wr_i = 1'b1;
    flag_wdata_i = 8'h00;
    tick();
    flag_wr_i = 1'b0;
    tick();
    chk("R3 write makes no trap", 32'(trap_take_o), 32'd0);
    chk("R3 write sets nothing", 32'(flags_o), 32'h00);
    cond_a_i = 3'b001;
    flag_wr_i = 1'b1;
    flag_wdata_i = 8'h00;
    tick();
    cond_a_i = '0;
    flag_wr_i = 1'b0;
    chk("R3 condition wins over clear", 32'(flags_o), 32'h01);
    drain();

    // R5: three class A together, served in order
    cond_a_i = 3'b111;
    tick();
    cond_a_i = '0;
    chk("R2 class A flags", 32'(flags_o), 32'h07);
    tick();
    chk("R5 first is NMI", 32'(trap_num_o), 32'h02);
    ack_expect(1'b1, 7'h04, "R5 overflow second");
    ack_expect(1'b1, 7'h06, "R5 underflow third");
    ack_expect(1'b0, 7'h00, "R5 nothing left");
    drain();

    // R6: all class B in one strobe
    raise(3'b000, 5'b11111);
    chk("R6 shared number", 32'(trap_num_o), 32'h0A);
    chk("R6 shared vector", 32'(trap_vec_o), 32'h28);
    ack_expect(1'b0, 7'h00, "R6 merged");
    drain();

    // R9: hold until acknowledge
    raise(3'b001, 5'b00000);
    chk("R9 first strobe", 32'(trap_take_o), 32'd1);
    cond_b_i = 5'b00010;
    tick();
    cond_b_i = '0;
    for (int w = 0; w < 4; w++) begin
      chk("R9 held without ack", 32'(trap_take_o), 32'd0);
      tick();
    end
    ack_expect(1'b1, 7'h0A, "R9 after ack");
    drain();

    // R8: second software request while pending is ignored
    raise(3'b001, 5'b00000);
    sw_trap_i = 1'b1;
    sw_num_i = 7'h11;
    cpu_lvl_i = 4'h3;
    tick();
    sw_num_i = 7'h12;
    cpu_lvl_i = 4'h7;
    tick();
    sw_trap_i = 1'b0;
    ack_expect(1'b1, 7'h11, "R8 first request kept");
    chk("R8 caller level", 32'(trap_prio_o), 32'd3);
    chk("R8 level code", 32'(trap_lvl_o), 32'd0);
    ack_expect(1'b0, 7'h00, "R8 second dropped");
    drain();

    // R10: reset request pre-empts an outstanding strobe
    raise(3'b001, 5'b00000);
    chk("R10 setup flag", 32'(flags_o), 32'h01);
    sw_rst_i = 1'b1;
    tick();
    sw_rst_i = 1'b0;
    chk("R10 no strobe yet", 32'(trap_take_o), 32'd0);
    tick();
    chk("R10 reset strobe", 32'(trap_take_o), 32'd1);
    chk("R10 number", 32'(trap_num_o), 32'd0);
    chk("R10 vector", 32'(trap_vec_o), 32'd0);
    chk("R10 level", 32'(trap_lvl_o), 32'd3);
    chk("R10 priority", 32'(trap_prio_o), 32'd15);
    chk("R10 flags cleared", 32'(flags_o), 32'd0);
    chk("R10 software cause", 32'(rst_cause_o), 32'd1);
    drain();
    sw_rst_i = 1'b1;
    wdt_rst_i = 1'b1;
    tick();
    sw_rst_i = 1'b0;
    wdt_rst_i = 1'b0;
    tick();
    chk("R10 watchdog strobe", 32'(trap_take_o), 32'd1);
    chk("R10 watchdog cause", 32'(rst_cause_o), 32'd2);
    drain();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule